// File: doc/BRIEF.md
# Packed Calendar Counter with Alarm

This block is a real-time counter peripheral sitting on a simple 32-bit register bus. Elapsed time is kept as one packed word holding day, hour, minute and second fields. The block is paced by an external `tick` strobe that pulses twice per second. Every counted tick raises a half-second event, and every second counted tick advances the time by one second. Carries ripple from seconds into minutes, hours and days. An hour/minute/second alarm is compared against the time as it advances. The resulting event flags drive two interrupt lines, one for periodic time events and one for the alarm.

Software writes to the counter and alarm registers do not take effect at once. They are staged and applied at the next tick boundary. A small write-staging state machine tracks this. It sits in `WS_IDLE` until a counter or alarm write arrives, which moves it to `WS_PEND`. On a tick with no new write in that cycle it applies every staged value and returns to `WS_IDLE`. A tick that coincides with a new write applies the older staged values and stays in `WS_PEND`. A status bit reads 1 only in `WS_IDLE`, so software can poll it to learn that its write has landed. The event flags are cleared by writing 1 to them, and a flag being set in the same cycle wins over the clear.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset, the counter, alarm, control, trim and event flags all read 0, status bit 16 (write done) reads 1, and both interrupt outputs are low.
- R2: Offset 0x00 reads 0x03011 in bits 31:12 and the revision parameter (default 0x001) in bits 11:0. Offset 0x20 is a plain 32-bit storage register that reads back what was written.
- R3: The counter at offset 0x10 holds seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and days in bits 31:17. While control bit 0 is set, every second counted tick advances it by one second. While control bit 0 is clear, ticks change neither the counter nor any flag.
- R4: Seconds and minutes wrap from 59 to 0 and hours wrap from 23 to 0, each carrying into the next field. The day field wraps from 32767 to 0.
- R5: A write to the counter (0x10) or the alarm (0x14) is applied on the first tick sampled after the write cycle, and a tick in the write cycle itself does not apply it. Status bit 16 reads 0 from the cycle after the write until that tick has applied it. Loading the counter restarts the half-second phase, so the next advance comes two counted ticks later.
- R6: The status register at offset 0x1C holds the event flags: bit 2 alarm, bit 3 day, bit 4 hour, bit 5 minute, bit 6 second, bit 7 half-second. The half-second flag sets on every counted tick and the second flag on every advance. The minute, hour and day flags set when the seconds, minutes and hours field wraps, respectively.
- R7: The alarm register at offset 0x14 uses the counter's second, minute and hour field positions. The alarm flag sets on an advance whose new hour, minute and second equal the alarm, whatever the day.
- R8: Writing 1 to a status flag bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as the clear leaves the flag set.
- R9: The control register at offset 0x18 keeps bits 7:0: bit 0 count enable, bit 1 alarm wakeup (storage only), and bits 2 to 7 as interrupt enables in the flag order of R6. `alarm_irq` is flag 2 AND enable 2. `time_irq` is the OR over bits 3 to 7 of flag AND enable.
- R10: Reads of unmapped offsets return 0, and writes to the identification register or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe at twice per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| time_irq | output | 1 | Periodic time-event interrupt |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The assertions assume that `tick` is a single-cycle strobe and that the bus presents at most one write per cycle. Under that assumption, any change of the counter can be traced back to a sampled tick, and any fall of the done bit to a counter or alarm write. The stimulus drives `tick` for exactly one cycle and gives counter and alarm writes only in-range field values. As a result, the carry chain sees only legal calendar values. Random traffic lets writes land in the same cycle as ticks, so the staging corner cases in `WS_PEND` are reached.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    localparam int OFS_ID   = 'h00;
    localparam int OFS_CNT  = 'h10;
    localparam int OFS_ALM  = 'h14;
    localparam int OFS_CTRL = 'h18;
    localparam int OFS_STAT = 'h1C;
    localparam int OFS_TRIM = 'h20;

    localparam logic [19:0] ID_CODE = 20'h03011;

    localparam int SEC_W = 6;
    localparam int MIN_W = 6;
    localparam int HR_W  = 5;
    localparam int DAY_W = 15;
    localparam int HMS_W = SEC_W + MIN_W + HR_W;

    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(59);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(59);
    localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(23);

    // bit positions shared by control enables and status flags
    localparam int B_RUN  = 0;
    localparam int B_WAKE = 1;
    localparam int B_ALM  = 2;
    localparam int B_DAY  = 3;
    localparam int B_HR   = 4;
    localparam int B_MIN  = 5;
    localparam int B_SEC  = 6;
    localparam int B_HALF = 7;
    localparam int B_DONE = 16;

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] mn;
        logic [SEC_W-1:0] sc;
    } rtc_time_t;

    typedef enum logic {WS_IDLE, WS_PEND} wr_state_e;
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  rtc_time_t        load_val,
    input  logic [HMS_W-1:0] alarm_hms,
    output rtc_time_t        cnt,
    output logic             evt_half,
    output logic             evt_sec,
    output logic             evt_min,
    output logic             evt_hour,
    output logic             evt_day,
    output logic             evt_alarm
);
    rtc_time_t cnt_q, nxt;
    logic      phase_q;
    logic      step, adv, sec_wrap, min_wrap, hr_wrap;

    always_comb begin
        step     = tick && run && !load;
        adv      = step && phase_q;
        sec_wrap = (cnt_q.sc >= SEC_LAST);
        min_wrap = (cnt_q.mn >= MIN_LAST);
        hr_wrap  = (cnt_q.hr >= HR_LAST);
        nxt      = cnt_q;
        if (adv) begin
            if (sec_wrap) begin
                nxt.sc = '0;
                if (min_wrap) begin
                    nxt.mn = '0;
                    if (hr_wrap) begin
                        nxt.hr  = '0;
                        nxt.day = cnt_q.day + 1'b1;
                    end else begin
                        nxt.hr = cnt_q.hr + 1'b1;
                    end
                end else begin
                    nxt.mn = cnt_q.mn + 1'b1;
                end
            end else begin
                nxt.sc = cnt_q.sc + 1'b1;
            end
        end
        evt_half  = step;
        evt_sec   = adv;
        evt_min   = adv && sec_wrap;
        evt_hour  = evt_min && min_wrap;
        evt_day   = evt_hour && hr_wrap;
        evt_alarm = adv && ({nxt.hr, nxt.mn, nxt.sc} == alarm_hms);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (load) begin
            cnt_q   <= load_val;
            phase_q <= 1'b0;
        end else if (step) begin
            cnt_q   <= nxt;
            phase_q <= ~phase_q;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/rtc_wr_stage.sv
module rtc_wr_stage
    import rtc_cal_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_cnt,
    input  logic              wr_alm,
    input  logic [DATA_W-1:0] wdata,
    output logic              apply_cnt,
    output logic              apply_alm,
    output logic [DATA_W-1:0] stg_cnt,
    output logic [HMS_W-1:0]  stg_alm,
    output logic              done
);
    wr_state_e         state_q, state_n;
    logic              pend_cnt_q, pend_alm_q;
    logic [DATA_W-1:0] stg_cnt_q;
    logic [HMS_W-1:0]  stg_alm_q;
    logic              any_wr;

    assign any_wr = wr_cnt || wr_alm;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            WS_IDLE: if (any_wr) state_n = WS_PEND;
            WS_PEND: if (tick && !any_wr) state_n = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= WS_IDLE;
            pend_cnt_q <= 1'b0;
            pend_alm_q <= 1'b0;
            stg_cnt_q  <= '0;
            stg_alm_q  <= '0;
        end else begin
            state_q    <= state_n;
            pend_cnt_q <= (pend_cnt_q && !tick) || wr_cnt;
            pend_alm_q <= (pend_alm_q && !tick) || wr_alm;
            if (wr_cnt) stg_cnt_q <= wdata;
            if (wr_alm) stg_alm_q <= wdata[HMS_W-1:0];
        end
    end

    always_comb begin
        apply_cnt = (state_q == WS_PEND) && tick && pend_cnt_q;
        apply_alm = (state_q == WS_PEND) && tick && pend_alm_q;
        stg_cnt   = stg_cnt_q;
        stg_alm   = stg_alm_q;
        done      = (state_q == WS_IDLE);
    end
endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top
    import rtc_cal_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 32,
    parameter logic [11:0] REV    = 12'h001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              time_irq,
    output logic              alarm_irq
);
    localparam int NFLAG = B_HALF + 1;

    logic [NFLAG-1:0]  ctrl_q, flags_q, evt_set;
    logic [HMS_W-1:0]  alarm_q, stg_alm;
    logic [DATA_W-1:0] trim_q, stg_cnt;
    logic              wr_cnt, wr_alm, wr_ctrl, wr_stat, wr_trim;
    logic              apply_cnt, apply_alm, wr_done;
    logic              e_half, e_sec, e_min, e_hour, e_day, e_alarm;
    rtc_time_t         cnt_w;

    assign wr_cnt  = wr_en && (addr == ADDR_W'(OFS_CNT));
    assign wr_alm  = wr_en && (addr == ADDR_W'(OFS_ALM));
    assign wr_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
    assign wr_stat = wr_en && (addr == ADDR_W'(OFS_STAT));
    assign wr_trim = wr_en && (addr == ADDR_W'(OFS_TRIM));

    rtc_wr_stage #(.DATA_W(DATA_W)) stage_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_cnt(wr_cnt), .wr_alm(wr_alm), .wdata(wdata),
        .apply_cnt(apply_cnt), .apply_alm(apply_alm),
        .stg_cnt(stg_cnt), .stg_alm(stg_alm), .done(wr_done)
    );

    rtc_time_core core_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl_q[B_RUN]),
        .load(apply_cnt), .load_val(rtc_time_t'(stg_cnt)), .alarm_hms(alarm_q),
        .cnt(cnt_w), .evt_half(e_half), .evt_sec(e_sec), .evt_min(e_min),
        .evt_hour(e_hour), .evt_day(e_day), .evt_alarm(e_alarm)
    );

    always_comb begin
        evt_set         = '0;
        evt_set[B_ALM]  = e_alarm;
        evt_set[B_DAY]  = e_day;
        evt_set[B_HR]   = e_hour;
        evt_set[B_MIN]  = e_min;
        evt_set[B_SEC]  = e_sec;
        evt_set[B_HALF] = e_half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            flags_q <= '0;
            alarm_q <= '0;
            trim_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata[NFLAG-1:0];
            if (wr_trim) trim_q <= wdata;
            if (apply_alm) alarm_q <= stg_alm;
            flags_q <= (flags_q & ~(wr_stat ? wdata[NFLAG-1:0] : '0)) | evt_set;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFS_ID):   rdata = {ID_CODE, REV};
            ADDR_W'(OFS_CNT):  rdata = DATA_W'(cnt_w);
            ADDR_W'(OFS_ALM):  rdata = DATA_W'(alarm_q);
            ADDR_W'(OFS_CTRL): rdata = DATA_W'(ctrl_q);
            ADDR_W'(OFS_STAT): rdata = DATA_W'({wr_done, 8'h00, flags_q});
            ADDR_W'(OFS_TRIM): rdata = trim_q;
            default:           rdata = '0;
        endcase
    end

    assign alarm_irq = flags_q[B_ALM] && ctrl_q[B_ALM];
    assign time_irq  = |(flags_q[B_HALF:B_DAY] & ctrl_q[B_HALF:B_DAY]);
endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk
    import rtc_cal_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick,
    input logic      wr_en,
    input logic [7:0] addr,
    input logic [7:0] ctrl,
    input rtc_time_t cnt,
    input logic      done,
    input logic      time_irq,
    input logic      alarm_irq
);
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    a_r3_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctrl[B_RUN] && done) |=> $stable(cnt));

    a_r5_write_lowers_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 8'(OFS_CNT) || addr == 8'(OFS_ALM))) |=> !done);

    a_r5_done_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(wr_en && (addr == 8'(OFS_CNT) || addr == 8'(OFS_ALM))));

    a_r9_alarm_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> ctrl[B_ALM]);

    a_r9_time_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        time_irq |-> (ctrl[B_HALF:B_DAY] != '0));
endmodule

bind rtc_cal_top rtc_cal_chk chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .ctrl(ctrl_q), .cnt(cnt_w), .done(wr_done),
    .time_irq(time_irq), .alarm_irq(alarm_irq)
);

// File: tb/rtc_cal_top_tb_top.sv
`timescale 1ns/1ps
module rtc_cal_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        time_irq, alarm_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rtc_cal_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .time_irq(time_irq), .alarm_irq(alarm_irq)
    );

    // behavioural reference state
    int          m_d = 0, m_h = 0, m_m = 0, m_s = 0;
    bit          m_ph = 0, m_pc = 0, m_pa = 0;
    logic [31:0] m_stg_c = 0, m_trim = 0;
    logic [16:0] m_stg_a = 0, m_alm = 0;
    logic [7:0]  m_ctrl = 0, m_flags = 0;

    function automatic logic [31:0] pack(int d, int h, int m, int s);
        return {d[14:0], h[4:0], m[5:0], s[5:0]};
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h00: return 32'h0301_1001;
            8'h10: return pack(m_d, m_h, m_m, m_s);
            8'h14: return {15'd0, m_alm};
            8'h18: return {24'd0, m_ctrl};
            8'h1C: return {15'd0, !(m_pc || m_pa), 8'd0, m_flags};
            8'h20: return m_trim;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(logic [7:0] a);
        case (a)
            8'h00: return "R2";
            8'h10: return "R3";
            8'h14: return "R7";
            8'h18: return "R9";
            8'h1C: return "R6";
            8'h20: return "R2";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit wc, wa, ws, wctl, wtr, do_c, do_a, run;
        logic [7:0] set;
        if (!rst_n) begin
            m_d = 0; m_h = 0; m_m = 0; m_s = 0; m_ph = 0; m_pc = 0; m_pa = 0;
            m_stg_c = 0; m_stg_a = 0; m_alm = 0; m_ctrl = 0; m_flags = 0; m_trim = 0;
        end else begin
            wc = wr_en && addr == 8'h10; wa = wr_en && addr == 8'h14;
            ws = wr_en && addr == 8'h1C; wctl = wr_en && addr == 8'h18;
            wtr = wr_en && addr == 8'h20;
            do_c = m_pc && tick; do_a = m_pa && tick; run = m_ctrl[0];
            set = 8'h00;
            if (do_c) begin
                m_d = int'(m_stg_c[31:17]); m_h = int'(m_stg_c[16:12]);
                m_m = int'(m_stg_c[11:6]);  m_s = int'(m_stg_c[5:0]);
                m_ph = 0;
            end else if (tick && run) begin
                set[7] = 1'b1;
                if (m_ph) begin
                    set[6] = 1'b1;
                    if (m_s == 59) begin
                        m_s = 0; set[5] = 1'b1;
                        if (m_m == 59) begin
                            m_m = 0; set[4] = 1'b1;
                            if (m_h == 23) begin
                                m_h = 0; set[3] = 1'b1; m_d = (m_d + 1) % 32768;
                            end else m_h++;
                        end else m_m++;
                    end else m_s++;
                    if (pack(0, m_h, m_m, m_s) == {15'd0, m_alm}) set[2] = 1'b1;
                end
                m_ph = !m_ph;
            end
            if (do_a) m_alm = m_stg_a;
            m_pc = (m_pc && !tick) || wc;
            m_pa = (m_pa && !tick) || wa;
            if (wc) m_stg_c = wdata;
            if (wa) m_stg_a = wdata[16:0];
            m_flags = (m_flags & ~(ws ? (wdata[7:0] & 8'hFC) : 8'h00)) | set;
            if (wctl) m_ctrl = wdata[7:0];
            if (wtr) m_trim = wdata;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        check(req_of(addr), rdata, m_read(addr));
        check("R9", {31'd0, time_irq}, {31'd0, |(m_flags[7:3] & m_ctrl[7:3])});
        check("R9", {31'd0, alarm_irq}, {31'd0, m_flags[2] & m_ctrl[2]});
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        @(negedge clk); #1;
        addr = a; #1;
        check(req, rdata, exp);
    endtask

    task automatic pulse(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1 tick = 1'b1;
            @(negedge clk); #1 tick = 1'b0;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        rd_chk("R1", 8'h10, 32'h0);
        rd_chk("R1", 8'h1C, 32'h0001_0000);
        rd_chk("R1", 8'h18, 32'h0);
        check("R1", {30'd0, time_irq, alarm_irq}, 32'h0);
        #1 rst_n = 1'b1;
        // R2 identification and trim
        rd_chk("R2", 8'h00, 32'h0301_1001);
        wr(8'h20, 32'hA5A5_5A5A);
        rd_chk("R2", 8'h20, 32'hA5A5_5A5A);
        // R10 identification write ignored, unmapped reads zero
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R10", 8'h00, 32'h0301_1001);
        wr(8'h24, 32'h1234_5678);
        rd_chk("R10", 8'h24, 32'h0);
        // R5 staged counter write
        wr(8'h10, pack(0, 23, 59, 58));
        rd_chk("R5", 8'h1C, 32'h0);
        rd_chk("R5", 8'h10, 32'h0);
        pulse(1);
        rd_chk("R5", 8'h10, pack(0, 23, 59, 58));
        rd_chk("R5", 8'h1C, 32'h0001_0000);
        // R3 counting, R4 carries, R6 flags
        wr(8'h18, 32'h1);
        pulse(2);
        rd_chk("R3", 8'h10, pack(0, 23, 59, 59));
        rd_chk("R6", 8'h1C, 32'h0001_00C0);
        pulse(2);
        rd_chk("R4", 8'h10, pack(1, 0, 0, 0));
        rd_chk("R6", 8'h1C, 32'h0001_00FC);
        // R8 write-one-to-clear
        wr(8'h1C, 32'h40);
        rd_chk("R8", 8'h1C, 32'h0001_00BC);
        wr(8'h1C, 32'hFC);
        rd_chk("R8", 8'h1C, 32'h0001_0000);
        // R4 day wrap
        wr(8'h10, pack(32767, 23, 59, 59));
        pulse(3);
        rd_chk("R4", 8'h10, 32'h0);
        // R7 alarm, day ignored; R9 interrupt gating
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'hFC);
        wr(8'h10, pack(5, 0, 0, 1));
        wr(8'h14, pack(0, 0, 0, 3));
        pulse(1);
        rd_chk("R7", 8'h14, 32'h3);
        wr(8'h18, 32'h05);
        pulse(2);
        rd_chk("R7", 8'h1C, 32'h0001_00C0);
        check("R9", {31'd0, alarm_irq}, 32'h0);
        pulse(2);
        rd_chk("R7", 8'h1C, 32'h0001_00C4);
        check("R9", {31'd0, alarm_irq}, 32'h1);
        check("R9", {31'd0, time_irq}, 32'h0);
        wr(8'h18, 32'h45);
        #2 check("R9", {31'd0, time_irq}, 32'h1);
        // R3 ticks ignored while disabled
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'hFC);
        pulse(4);
        rd_chk("R3", 8'h10, pack(5, 0, 0, 3));
        rd_chk("R3", 8'h1C, 32'h0001_0000);
        // mixed traffic against the reference model
        for (int i = 0; i < 4000; i++) begin
            int k;
            @(negedge clk); #1;
            tick = ($urandom_range(0, 2) == 0);
            wr_en = ($urandom_range(0, 3) == 0);
            k = $urandom_range(0, 6);
            case (k)
                0: addr = 8'h00;
                1: addr = 8'h10;
                2: addr = 8'h14;
                3: addr = 8'h18;
                4: addr = 8'h1C;
                5: addr = 8'h20;
                default: addr = 8'h24;
            endcase
            if (k == 1 || k == 2)
                wdata = pack($urandom_range(0, 32767), $urandom_range(0, 23),
                             $urandom_range(0, 59), $urandom_range(50, 59));
            else if (k == 3)
                wdata = {$urandom} | 32'h1;
            else
                wdata = $urandom;
        end
        @(negedge clk); #1;
        tick = 1'b0; wr_en = 1'b0;
        repeat (4) @(negedge clk);
        summary();
    end
endmodule